// File: doc/BRIEF.md
# Overlay Window Region and Fetch Address Generator

This block serves one hardware overlay window of a display pipeline. Each cycle it compares the screen position supplied by a timing generator against the window's rectangle. One cycle later it reports whether that pixel belongs to the window.

For every screen line that crosses the window's rows, it also emits a stream of frame-buffer byte addresses, one per cycle. Each address carries a burst length chosen from the pixel depth. The line address walks the buffer by page width plus a per-line skip. It returns to the buffer start on every frame strobe. No request is made at or past the buffer end.

The configuration inputs are staged. They are copied into the active set on a frame strobe, unless the window's protect input is held high. A live channel-enable input gates the fetch stream without disturbing the line walk. The burst length for a given depth is fixed by a small table in the package.

Top module: `ovl_win_gen`

## Requirements
- R1: `in_window` is 1 in the cycle after `pix_x`/`pix_y` lie inside the active rectangle, when the window is enabled. Both corners are inclusive: tl_x <= x <= br_x and tl_y <= y <= br_y.
- R2: `in_window` is 0 in the cycle after a position outside the rectangle, and always 0 while the active window enable is 0.
- R3: `req_burst` gives the burst length in 4-byte words for the active depth. It is 4 at 1 bit per pixel, 8 at 2, 4 and 8 bits, and 16 at 16, 24 and 32 bits.
- R4: Any other depth value, including 0, gives the 24-bit result of 16 words.
- R5: A `line_start` pulse in IDLE, with `pix_y` inside the active rows, starts requests in the next cycle at the current line address. One request is issued per cycle, each address is the previous one plus burst words times 4, and the number of requests is ceil(page bytes / burst bytes).
- R6: Each `line_start` on a window row with the window enabled advances the line address by page bytes plus line skip. This holds whether or not the channel is enabled.
- R7: `frame_start` reloads the line address with the buffer start, cancels any burst in progress, and gives no request in the following cycle.
- R8: No request address is ever at or above the active buffer end. A line whose address has reached the end issues nothing.
- R9: On `frame_start`, staged configuration becomes active only when `cfg_protect` is 0. With `cfg_protect` at 1 the active set is kept.
- R10: While `cfg_chan_en` is 0, no request is issued.
- R11: After reset, `in_window` and `req_valid` are 0 and the window is disabled.
- R12: A `line_start` with `pix_y` outside the active rows issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | CW | Current screen column |
| pix_y | input | CW | Current screen row |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| frame_start | input | 1 | One-cycle strobe at vertical sync |
| cfg_buf_start | input | AW | Staged buffer start byte address |
| cfg_buf_end | input | AW | Staged buffer end byte address (exclusive) |
| cfg_page_bytes | input | PW | Staged bytes fetched per window line |
| cfg_line_skip | input | PW | Staged bytes skipped after each line |
| cfg_tl_x | input | CW | Staged top-left column |
| cfg_tl_y | input | CW | Staged top-left row |
| cfg_br_x | input | CW | Staged bottom-right column (inclusive) |
| cfg_br_y | input | CW | Staged bottom-right row (inclusive) |
| cfg_bpp | input | BPPW | Staged bits per pixel |
| cfg_win_en | input | 1 | Staged window enable |
| cfg_protect | input | 1 | Holds the active set at frame strobes |
| cfg_chan_en | input | 1 | Live fetch channel enable |
| in_window | output | 1 | Previous cycle's position lies in the window |
| req_valid | output | 1 | Fetch request present this cycle |
| req_addr | output | AW | Fetch request byte address |
| req_burst | output | 5 | Burst length in words |

## Verification
The bench uses the default widths: 32-bit addresses, 12-bit coordinates, 16-bit page and skip fields, 6-bit depth and 4-byte words. The 6-bit depth field reaches every legal depth and several illegal ones.

A 40-byte page at 8 bits per pixel gives two 32-byte bursts per line, the second one partial. This shows the burst stepping and the ceiling count. Moving the buffer end into the middle of a line exposes the cut-off at the end address.

The 12-bit coordinates allow columns on either side of both corners, so the inclusive edges and the one-beyond cases are each exercised.

// File: rtl/ovl_win_pkg.sv
// Shared definitions for the overlay window generator.
// Assumes a word is four bytes; depth values are plain bit counts.
package ovl_win_pkg;

    typedef enum logic {FS_IDLE = 1'b0, FS_BURST = 1'b1} fetch_state_t;

    // Burst length in words for a depth; unknown depths use the 24-bit choice.
    function automatic logic [4:0] burst_words_f(input logic [7:0] bpp);
        case (bpp)
            8'd1:                      return 5'd4;
            8'd2, 8'd4, 8'd8:          return 5'd8;
            8'd16, 8'd24, 8'd32:       return 5'd16;
            default:                   return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/ovl_win_shadow.sv
// Holds the active window configuration and loads it from the staged
// inputs on a frame strobe unless protect is high.
// Assumes frame_start is a single-cycle pulse.
module ovl_win_shadow #(
    parameter int AW   = 32,
    parameter int CW   = 12,
    parameter int PW   = 16,
    parameter int BPPW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            cfg_protect,
    input  logic [AW-1:0]   cfg_buf_start,
    input  logic [AW-1:0]   cfg_buf_end,
    input  logic [PW-1:0]   cfg_page_bytes,
    input  logic [PW-1:0]   cfg_line_skip,
    input  logic [CW-1:0]   cfg_tl_x,
    input  logic [CW-1:0]   cfg_tl_y,
    input  logic [CW-1:0]   cfg_br_x,
    input  logic [CW-1:0]   cfg_br_y,
    input  logic [BPPW-1:0] cfg_bpp,
    input  logic            cfg_win_en,
    output logic [AW-1:0]   reload_start,
    output logic [AW-1:0]   act_end,
    output logic [PW-1:0]   act_page,
    output logic [PW-1:0]   act_skip,
    output logic [CW-1:0]   act_tlx,
    output logic [CW-1:0]   act_tly,
    output logic [CW-1:0]   act_brx,
    output logic [CW-1:0]   act_bry,
    output logic [BPPW-1:0] act_bpp,
    output logic            act_en
);
    logic          load;
    logic [AW-1:0] act_start;

    // Shadow load happens on an unprotected frame strobe.
    assign load = frame_start && !cfg_protect;

    // Start address the fetch walk reloads with at this frame strobe.
    assign reload_start = load ? cfg_buf_start : act_start;

    // Active register set, cleared by reset and loaded at frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_start <= '0;
            act_end   <= '0;
            act_page  <= '0;
            act_skip  <= '0;
            act_tlx   <= '0;
            act_tly   <= '0;
            act_brx   <= '0;
            act_bry   <= '0;
            act_bpp   <= '0;
            act_en    <= 1'b0;
        end else if (load) begin
            act_start <= cfg_buf_start;
            act_end   <= cfg_buf_end;
            act_page  <= cfg_page_bytes;
            act_skip  <= cfg_line_skip;
            act_tlx   <= cfg_tl_x;
            act_tly   <= cfg_tl_y;
            act_brx   <= cfg_br_x;
            act_bry   <= cfg_br_y;
            act_bpp   <= cfg_bpp;
            act_en    <= cfg_win_en;
        end
    end
endmodule

// File: rtl/ovl_win_region.sv
// Registers whether the current position lies inside the inclusive
// window rectangle. Assumes tl <= br; otherwise the window is empty.
module ovl_win_region #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic [CW-1:0] tlx,
    input  logic [CW-1:0] tly,
    input  logic [CW-1:0] brx,
    input  logic [CW-1:0] bry,
    input  logic          en,
    output logic          in_window
);
    logic hit;

    // Inclusive rectangle compare on both axes.
    assign hit = en && (pix_x >= tlx) && (pix_x <= brx)
                    && (pix_y >= tly) && (pix_y <= bry);

    // One-cycle registered flag.
    always_ff @(posedge clk) begin
        if (!rst_n) in_window <= 1'b0;
        else        in_window <= hit;
    end
endmodule

// File: rtl/ovl_win_fetch.sv
// Walks the frame buffer line by line and issues one burst request per
// cycle for each window row. Assumes line_start only arrives when idle
// is acceptable: strobes during a burst are ignored.
module ovl_win_fetch #(
    parameter int AW         = 32,
    parameter int CW         = 12,
    parameter int PW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic [CW-1:0] pix_y,
    input  logic [CW-1:0] tly,
    input  logic [CW-1:0] bry,
    input  logic          win_en,
    input  logic          chan_en,
    input  logic [AW-1:0] reload_start,
    input  logic [AW-1:0] buf_end,
    input  logic [PW-1:0] page,
    input  logic [PW-1:0] skip,
    input  logic [4:0]    burst_words,
    output logic          req_valid,
    output logic [AW-1:0] req_addr
);
    import ovl_win_pkg::*;

    localparam int WSH = $clog2(WORD_BYTES);

    fetch_state_t  state;
    logic [AW-1:0] line_addr;
    logic [AW-1:0] cur;
    logic [AW-1:0] rem;
    logic [AW-1:0] bb;
    logic [AW-1:0] cur_next;
    logic          row_hit;

    // Burst size in bytes and the next burst address.
    assign bb       = AW'(burst_words) << WSH;
    assign cur_next = cur + bb;

    // Row of the strobe lies in the window's inclusive row range.
    assign row_hit = (pix_y >= tly) && (pix_y <= bry);

    // Line walk and burst sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_IDLE;
            line_addr <= '0;
            cur       <= '0;
            rem       <= '0;
        end else if (frame_start) begin
            state     <= FS_IDLE;
            line_addr <= reload_start;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (line_start && row_hit && win_en) begin
                        line_addr <= line_addr + AW'(page) + AW'(skip);
                        if (chan_en && (line_addr < buf_end) && (page != '0)) begin
                            state <= FS_BURST;
                            cur   <= line_addr;
                            rem   <= AW'(page);
                        end
                    end
                end
                FS_BURST: begin
                    cur <= cur_next;
                    if ((rem <= bb) || (cur_next >= buf_end) || !chan_en)
                        state <= FS_IDLE;
                    else
                        rem <= rem - bb;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign req_valid = (state == FS_BURST);
    assign req_addr  = cur;
endmodule

// File: rtl/ovl_win_gen.sv
// Top of the overlay window generator: shadowed configuration, region
// flag and fetch address stream for one window.
// Assumes line_start and frame_start come from one timing generator.
module ovl_win_gen #(
    parameter int AW         = 32,
    parameter int CW         = 12,
    parameter int PW         = 16,
    parameter int BPPW       = 6,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   pix_x,
    input  logic [CW-1:0]   pix_y,
    input  logic            line_start,
    input  logic            frame_start,
    input  logic [AW-1:0]   cfg_buf_start,
    input  logic [AW-1:0]   cfg_buf_end,
    input  logic [PW-1:0]   cfg_page_bytes,
    input  logic [PW-1:0]   cfg_line_skip,
    input  logic [CW-1:0]   cfg_tl_x,
    input  logic [CW-1:0]   cfg_tl_y,
    input  logic [CW-1:0]   cfg_br_x,
    input  logic [CW-1:0]   cfg_br_y,
    input  logic [BPPW-1:0] cfg_bpp,
    input  logic            cfg_win_en,
    input  logic            cfg_protect,
    input  logic            cfg_chan_en,
    output logic            in_window,
    output logic            req_valid,
    output logic [AW-1:0]   req_addr,
    output logic [4:0]      req_burst
);
    import ovl_win_pkg::*;

    logic [AW-1:0]   reload_start;
    logic [AW-1:0]   act_end;
    logic [PW-1:0]   act_page;
    logic [PW-1:0]   act_skip;
    logic [CW-1:0]   act_tlx;
    logic [CW-1:0]   act_tly;
    logic [CW-1:0]   act_brx;
    logic [CW-1:0]   act_bry;
    logic [BPPW-1:0] act_bpp;
    logic            act_en;

    ovl_win_shadow #(.AW(AW), .CW(CW), .PW(PW), .BPPW(BPPW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_protect(cfg_protect), .cfg_buf_start(cfg_buf_start),
        .cfg_buf_end(cfg_buf_end), .cfg_page_bytes(cfg_page_bytes),
        .cfg_line_skip(cfg_line_skip), .cfg_tl_x(cfg_tl_x),
        .cfg_tl_y(cfg_tl_y), .cfg_br_x(cfg_br_x), .cfg_br_y(cfg_br_y),
        .cfg_bpp(cfg_bpp), .cfg_win_en(cfg_win_en),
        .reload_start(reload_start), .act_end(act_end),
        .act_page(act_page), .act_skip(act_skip), .act_tlx(act_tlx),
        .act_tly(act_tly), .act_brx(act_brx), .act_bry(act_bry),
        .act_bpp(act_bpp), .act_en(act_en)
    );

    ovl_win_region #(.CW(CW)) u_region (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .tlx(act_tlx), .tly(act_tly), .brx(act_brx), .bry(act_bry),
        .en(act_en), .in_window(in_window)
    );

    // Burst length follows the active depth.
    assign req_burst = burst_words_f(8'(act_bpp));

    ovl_win_fetch #(.AW(AW), .CW(CW), .PW(PW), .WORD_BYTES(WORD_BYTES)) u_fetch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .pix_y(pix_y), .tly(act_tly),
        .bry(act_bry), .win_en(act_en), .chan_en(cfg_chan_en),
        .reload_start(reload_start), .buf_end(act_end), .page(act_page),
        .skip(act_skip), .burst_words(req_burst),
        .req_valid(req_valid), .req_addr(req_addr)
    );
endmodule

// File: rtl/ovl_win_gen_chk.sv
// Property checker for ovl_win_gen, attached through bind below.
module ovl_win_gen_chk #(
    parameter int AW         = 32,
    parameter int CW         = 12,
    parameter int WORD_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic          frame_start,
    input logic          cfg_chan_en,
    input logic          in_window,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [4:0]    req_burst,
    input logic [AW-1:0] act_end,
    input logic [CW-1:0] act_tlx,
    input logic [CW-1:0] act_tly,
    input logic [CW-1:0] act_brx,
    input logic [CW-1:0] act_bry
);
    localparam int WSH = $clog2(WORD_BYTES);

    AST_INSIDE_RECT: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> ($past(pix_x) >= $past(act_tlx)) && ($past(pix_x) <= $past(act_brx))
                   && ($past(pix_y) >= $past(act_tly)) && ($past(pix_y) <= $past(act_bry))); // R1

    AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_burst == 5'd4) || (req_burst == 5'd8) || (req_burst == 5'd16)); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |->
            (req_addr == $past(req_addr) + (AW'($past(req_burst)) << WSH))); // R5

    AST_FRAME_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> !req_valid); // R7

    AST_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr < act_end)); // R8

    AST_CHAN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(cfg_chan_en)); // R10
endmodule

bind ovl_win_gen ovl_win_gen_chk #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) i_chk (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start), .cfg_chan_en(cfg_chan_en),
    .in_window(in_window), .req_valid(req_valid), .req_addr(req_addr),
    .req_burst(req_burst), .act_end(act_end), .act_tlx(act_tlx),
    .act_tly(act_tly), .act_brx(act_brx), .act_bry(act_bry)
);

// File: tb/test_ovl_win_gen.sv
// Self-checking bench for ovl_win_gen: vector tables for the region flag
// and burst length, then directed fetch, shadow and reset cases.
module test_ovl_win_gen;
    localparam int AW = 32, CW = 12, PW = 16, BPPW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   pix_x = '0, pix_y = '0;
    logic            line_start = 1'b0, frame_start = 1'b0;
    logic [AW-1:0]   cfg_buf_start = 32'h1000, cfg_buf_end = 32'h1100;
    logic [PW-1:0]   cfg_page_bytes = 16'd40, cfg_line_skip = 16'd24;
    logic [CW-1:0]   cfg_tl_x = 12'd10, cfg_tl_y = 12'd5;
    logic [CW-1:0]   cfg_br_x = 12'd49, cfg_br_y = 12'd8;
    logic [BPPW-1:0] cfg_bpp = 6'd8;
    logic            cfg_win_en = 1'b1, cfg_protect = 1'b0, cfg_chan_en = 1'b1;
    logic            in_window, req_valid;
    logic [AW-1:0]   req_addr;
    logic [4:0]      req_burst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ovl_win_gen #(.AW(AW), .CW(CW), .PW(PW), .BPPW(BPPW)) i_ovl_win_gen (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .line_start(line_start), .frame_start(frame_start),
        .cfg_buf_start(cfg_buf_start), .cfg_buf_end(cfg_buf_end),
        .cfg_page_bytes(cfg_page_bytes), .cfg_line_skip(cfg_line_skip),
        .cfg_tl_x(cfg_tl_x), .cfg_tl_y(cfg_tl_y), .cfg_br_x(cfg_br_x),
        .cfg_br_y(cfg_br_y), .cfg_bpp(cfg_bpp), .cfg_win_en(cfg_win_en),
        .cfg_protect(cfg_protect), .cfg_chan_en(cfg_chan_en),
        .in_window(in_window), .req_valid(req_valid), .req_addr(req_addr),
        .req_burst(req_burst)
    );

    // Region vectors {x, y, expected} for rectangle (10,5)-(49,8): R1, R2.
    localparam logic [24:0] REGION_TBL [10] = '{
        {12'd10, 12'd5, 1'b1}, {12'd49, 12'd8, 1'b1}, {12'd9,  12'd5, 1'b0},
        {12'd50, 12'd5, 1'b0}, {12'd10, 12'd4, 1'b0}, {12'd10, 12'd9, 1'b0},
        {12'd30, 12'd6, 1'b1}, {12'd49, 12'd5, 1'b1}, {12'd10, 12'd8, 1'b1},
        {12'd0,  12'd0, 1'b0}
    };

    // Burst vectors {bpp, words}: R3 legal depths, R4 fallback.
    localparam logic [10:0] BURST_TBL [10] = '{
        {6'd1, 5'd4}, {6'd2, 5'd8}, {6'd4, 5'd8}, {6'd8, 5'd8},
        {6'd16, 5'd16}, {6'd24, 5'd16}, {6'd32, 5'd16},
        {6'd5, 5'd16}, {6'd12, 5'd16}, {6'd0, 5'd16}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic region_check(input logic [CW-1:0] x, input logic [CW-1:0] y,
                                input logic exp, input string tag);
        @(negedge clk) begin pix_x = x; pix_y = y; end
        @(negedge clk) check(in_window == exp, tag, in_window, exp);
    endtask

    // Pulse one line strobe and compare the request stream that follows.
    task automatic run_line(input logic [CW-1:0] y, input int n_exp,
                            input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                            input string tag);
        logic [AW-1:0] got [8];
        int n = 0;
        @(negedge clk) begin pix_y = y; line_start = 1'b1; end
        @(negedge clk) line_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (req_valid) begin
                if (n < 8) got[n] = req_addr;
                n++;
            end
            @(negedge clk);
        end
        check(n == n_exp, {tag, " count"}, n, n_exp);
        if (n_exp > 0 && n > 0) check(got[0] == a0, {tag, " addr0"}, got[0], a0);
        if (n_exp > 1 && n > 1) check(got[1] == a1, {tag, " addr1"}, got[1], a1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: quiet outputs while and after reset, window disabled.
        check(in_window == 1'b0, "R11 in_window", in_window, 0);
        check(req_valid == 1'b0, "R11 req_valid", req_valid, 0);
        rst_n = 1'b1;
        run_line(12'd0, 0, '0, '0, "R11 disabled after reset");

        pulse_frame();
        foreach (REGION_TBL[i])
            region_check(REGION_TBL[i][24:13], REGION_TBL[i][12:1], REGION_TBL[i][0], "R1 R2 region");

        // R2: window disable masks an inside position.
        cfg_win_en = 1'b0; pulse_frame();
        region_check(12'd30, 12'd6, 1'b0, "R2 disabled");
        cfg_win_en = 1'b1; pulse_frame();

        foreach (BURST_TBL[i]) begin
            cfg_bpp = BURST_TBL[i][10:5];
            pulse_frame();
            @(negedge clk) check(req_burst == BURST_TBL[i][4:0], "R3 R4 burst", req_burst, BURST_TBL[i][4:0]);
        end
        cfg_bpp = 6'd8; pulse_frame();

        // Line walk: 40-byte page in 32-byte bursts, 64-byte stride.
        run_line(12'd4, 0, '0, '0, "R12 above window");
        run_line(12'd5, 2, 32'h1000, 32'h1020, "R5 first line");
        run_line(12'd6, 2, 32'h1040, 32'h1060, "R6 second line");
        run_line(12'd7, 2, 32'h1080, 32'h10A0, "R6 third line");
        run_line(12'd8, 2, 32'h10C0, 32'h10E0, "R6 last line");
        run_line(12'd9, 0, '0, '0, "R12 below window");
        pulse_frame();
        run_line(12'd5, 2, 32'h1000, 32'h1020, "R7 reload");

        // R10: channel off blocks requests but the walk still advances (R6).
        cfg_chan_en = 1'b0;
        run_line(12'd6, 0, '0, '0, "R10 channel off");
        cfg_chan_en = 1'b1;
        run_line(12'd7, 2, 32'h1080, 32'h10A0, "R10 R6 after channel off");

        // R8: end address inside the third line.
        cfg_buf_end = 32'h1090; pulse_frame();
        run_line(12'd5, 2, 32'h1000, 32'h1020, "R8 line0");
        run_line(12'd6, 2, 32'h1040, 32'h1060, "R8 line1");
        run_line(12'd7, 1, 32'h1080, '0, "R8 partial");
        run_line(12'd8, 0, '0, '0, "R8 past end");
        cfg_buf_end = 32'h1100;

        // R9: protect keeps the active rectangle until released.
        cfg_protect = 1'b1; cfg_tl_x = 12'd0; pulse_frame();
        region_check(12'd5, 12'd6, 1'b0, "R9 protected");
        cfg_protect = 1'b0; pulse_frame();
        region_check(12'd5, 12'd6, 1'b1, "R9 released");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule